// File: doc/BRIEF.md
# ADC Channel Scan and Trigger Controller

This block sequences conversions for a six-input successive-approximation converter. A CPU reads and writes two byte registers: a control byte and a trigger byte. The control byte holds the channel code, the mode, the start/busy bit, an interrupt enable and the end-of-conversion flag. The trigger byte picks whether a timer pulse or an external pin may also start a run.

In single mode one channel is converted and the busy bit then drops by itself. In scan mode a group of channels is converted in a loop until software clears busy. The group starts at channel 0 or channel 4 and holds up to four channels. For each conversion the block raises a one-cycle request with a channel number to the converter core. It waits for the core's done pulse and stores the returned word in a per-channel result register. The CPU reads those registers through a separate read port.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Single mode (control bit 4 = 0): channel code c in 0..5 (control bits 2:0) converts channel c exactly once.
- R2: Scan mode (control bit 4 = 1): code 000 loops {0}, 001 loops {0,1}, 010 loops {0,1,2}, 011 loops {0,1,2,3}, 100 loops {4}, 101 loops {4,5}, always in ascending order.
- R3: Trigger byte (address 1) bits 7:6 select the hardware start source: 00 and 01 allow none, 10 allows a high pulse on tmr_trig, and 11 allows a falling edge of ext_trig_n. The pin passes through two synchroniser flops before edge detection.
- R4: The channel code, the scan bit and the trigger-select field keep their value when written while busy (control bit 5) is 1.
- R5: Trigger byte bits 5:0 always read as 1 and ignore writes. Control bit 3 reads 0.
- R6: The end flag (control bit 7) is set only by hardware. A control write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it unchanged.
- R7: A start, from software or hardware, with channel code 110 or 111 issues no request and leaves busy at 0.
- R8: In single mode busy clears after the conversion. In scan mode busy stays 1 and the group repeats. The end flag is set when the last channel of the group completes, once per pass.
- R9: conv_start is a one-cycle pulse with conv_ch valid. The result of each conversion is readable at rd_result when rd_ch equals its channel.
- R10: Hardware triggers that arrive while busy is 1 start nothing extra.
- R11: irq equals the end flag ANDed with the interrupt enable (control bit 6).
- R12: Writing busy = 0 aborts a run. A done pulse for an aborted request changes neither a result nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control byte, 1 = trigger byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed byte |
| rd_ch | input | 3 | Result register select |
| rd_result | output | RES_W | Stored result of channel rd_ch |
| tmr_trig | input | 1 | Timer start pulse |
| ext_trig_n | input | 1 | Asynchronous external start pin, falling-edge active |
| conv_start | output | 1 | Conversion request pulse to the core |
| conv_ch | output | 3 | Channel for the current request |
| conv_done | input | 1 | Core completion pulse |
| conv_result | input | RES_W | Core result word, valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the group decode at both anchors, including the one-channel groups 000 and 100. A wrong decode would convert channel 1 or 5 where it should not, or wrap to the wrong first channel. It starts runs with codes 110 and 111, where a missing legality gate would send an out-of-range channel to the core. It writes configuration and trigger bytes mid-run, fires triggers while busy and on the pin's rising edge, and writes 1 to the flag. Each of these would show up as a changed field, an extra request or a flag that never clears. It also aborts a run with a request in flight, so a late done pulse that is still accepted would overwrite a stored result.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             reg_addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [2:0]       rd_ch,
  output logic [RES_W-1:0] rd_result,
  input  logic             tmr_trig,
  input  logic             ext_trig_n,
  output logic             conv_start,
  output logic [2:0]       conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             irq
);
  localparam int NCH = 6;

  logic [2:0]       ch, cur;
  logic             scan, busy, ie, flag, inflight, start_q;
  logic [1:0]       tsel;
  logic [2:0]       pin_s;
  logic [RES_W-1:0] res [NCH];

  logic       wr_ctrl, wr_trig, stop, hw_trig, go, legal, scan_n;
  logic [2:0] ch_n, first_n, first_c, last_c;

  assign wr_ctrl = wr_en & ~reg_addr;
  assign wr_trig = wr_en & reg_addr;
  assign stop    = wr_ctrl & ~wdata[5];
  assign ch_n    = (wr_ctrl & ~busy) ? wdata[2:0] : ch;
  assign scan_n  = (wr_ctrl & ~busy) ? wdata[4] : scan;
  assign legal   = ~(ch_n[2] & ch_n[1]);
  assign hw_trig = ((tsel == 2'b10) & tmr_trig) | ((tsel == 2'b11) & pin_s[2] & ~pin_s[1]);
  assign go      = ~busy & legal & ((wr_ctrl & wdata[5]) | hw_trig);
  assign first_n = scan_n ? {ch_n[2], 2'b00} : ch_n;
  assign first_c = scan ? {ch[2], 2'b00} : ch;
  assign last_c  = scan ? (ch[2] ? {2'b10, ch[0]} : {1'b0, ch[1:0]}) : ch;

  assign rdata      = reg_addr ? {tsel, 6'h3f} : {flag, ie, busy, scan, 1'b0, ch};
  assign rd_result  = (rd_ch < 3'(NCH)) ? res[rd_ch] : '0;
  assign conv_start = start_q;
  assign conv_ch    = cur;
  assign irq        = flag & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch       <= '0;
      cur      <= '0;
      scan     <= 1'b0;
      busy     <= 1'b0;
      ie       <= 1'b0;
      flag     <= 1'b0;
      inflight <= 1'b0;
      start_q  <= 1'b0;
      tsel     <= '0;
      pin_s    <= '1;
      for (int i = 0; i < NCH; i++) res[i] <= '0;
    end else begin
      pin_s   <= {pin_s[1:0], ext_trig_n};
      start_q <= 1'b0;
      if (wr_ctrl) begin
        ie <= wdata[6];
        if (!busy) begin
          ch   <= wdata[2:0];
          scan <= wdata[4];
        end
      end
      if (wr_trig && !busy) tsel <= wdata[7:6];

      if (busy && inflight && conv_done && !stop && cur == last_c) flag <= 1'b1;
      else if (wr_ctrl && !wdata[7]) flag <= 1'b0;

      if (go) begin
        busy     <= 1'b1;
        cur      <= first_n;
        inflight <= 1'b0;
      end else if (stop) begin
        busy     <= 1'b0;
        inflight <= 1'b0;
      end else if (busy) begin
        if (!inflight) begin
          start_q  <= 1'b1;
          inflight <= 1'b1;
        end else if (conv_done) begin
          res[cur] <= conv_result;
          inflight <= 1'b0;
          if (cur == last_c) begin
            cur <= first_c;
            if (!scan) busy <= 1'b0;
          end else begin
            cur <= cur + 3'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_start,
  input logic       conv_done,
  input logic [2:0] conv_ch,
  input logic [2:0] ch,
  input logic [1:0] tsel,
  input logic       busy,
  input logic       flag
);
  a_r9_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r7_legal_channel: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_ch < 3'd6));

  a_r4_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ch) && $stable(tsel)));

  a_r6_flag_by_hw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(conv_done));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .conv_ch(conv_ch), .ch(ch), .tsel(tsel), .busy(busy), .flag(flag)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int RW = 10;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, reg_addr = 1'b0;
  logic [7:0]    wdata = '0, rdata;
  logic [2:0]    rd_ch = '0;
  logic [RW-1:0] rd_result;
  logic          tmr_trig = 1'b0, ext_trig_n = 1'b1;
  logic          conv_start, conv_done = 1'b0, irq;
  logic [2:0]    conv_ch;
  logic [RW-1:0] conv_result = '0;

  int total = 0, bad = 0;
  int roff = 5;
  int lat_cnt = 0;
  logic [2:0] lat_ch = '0;
  int nlog = 0;
  logic [2:0] log_ch [64];

  always #10 clk = ~clk;

  adc_seq_ctrl #(.RES_W(RW)) u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wdata(wdata),
    .rdata(rdata), .rd_ch(rd_ch), .rd_result(rd_result), .tmr_trig(tmr_trig),
    .ext_trig_n(ext_trig_n), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
  );

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      lat_cnt <= 3;
      lat_ch  <= conv_ch;
    end else if (lat_cnt > 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        conv_done   <= 1'b1;
        conv_result <= RW'(int'(lat_ch) * 37 + roff);
      end
    end
    if (conv_start && nlog < 64) begin
      log_ch[nlog] <= conv_ch;
      nlog <= nlog + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(1'b0, d);
      if (!d[5]) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, d); check("R6 reset control", d, 8'h00);
    rd(1'b1, d); check("R5 reset trigger byte", d, 8'h3f);
    check("R11 reset irq", irq, 0);
  endtask

  task automatic t_single();
    logic [7:0] d;
    for (int c = 0; c < 6; c++) begin
      int n0 = nlog;
      wr(1'b0, 8'h20 | 8'(c));
      wait_idle();
      repeat (2) @(negedge clk);
      check("R1 one request", nlog - n0, 1);
      check("R1 channel", log_ch[n0], c);
      rd(1'b0, d);
      check("R8 single busy clear", d[5], 0);
      check("R8 flag set", d[7], 1);
      rd_ch = 3'(c); #1;
      check("R9 stored result", rd_result, (c * 37 + roff) & 10'h3ff);
      wr(1'b0, 8'(c));
    end
  endtask

  task automatic t_flag();
    logic [7:0] d;
    wr(1'b0, 8'h80);
    rd(1'b0, d); check("R6 write 1 does not set", d[7], 0);
    wr(1'b0, 8'h20);
    wait_idle();
    wr(1'b0, 8'h80);
    rd(1'b0, d); check("R6 write 1 keeps flag", d[7], 1);
    wr(1'b0, 8'h00);
    rd(1'b0, d); check("R6 write 0 clears", d[7], 0);
  endtask

  task automatic t_scan(input logic [2:0] code, input int n, input int g0, input int gn);
    logic [7:0] d;
    int n0 = nlog;
    wr(1'b0, 8'h30 | 8'(code));
    for (int i = 0; i < 400 && nlog < n0 + n + 1; i++) @(negedge clk);
    rd(1'b0, d);
    check("R8 scan still busy", d[5], 1);
    check("R8 scan flag", d[7], 1);
    wr(1'b0, 8'h00);
    repeat (10) @(negedge clk);
    rd(1'b0, d);
    check("R12 stopped", d[5], 0);
    for (int i = 0; i < n; i++)
      check($sformatf("R2 scan code %0d step %0d", code, i), log_ch[n0 + i], g0 + (i % gn));
  endtask

  task automatic t_lock();
    logic [7:0] d;
    wr(1'b0, 8'h31);
    wr(1'b0, 8'h22);
    wr(1'b1, 8'hc0);
    rd(1'b0, d);
    check("R4 channel locked", d[2:0], 1);
    check("R4 scan locked", d[4], 1);
    rd(1'b1, d); check("R4 trigger locked", d, 8'h3f);
    wr(1'b0, 8'h00);
    repeat (10) @(negedge clk);
    wr(1'b1, 8'h80);
    rd(1'b1, d); check("R5 reserved bits stay 1", d, 8'hbf);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_illegal();
    logic [7:0] d;
    int n0 = nlog;
    wr(1'b0, 8'h26);
    rd(1'b0, d); check("R7 busy stays 0 code 110", d[5], 0);
    wr(1'b0, 8'h37);
    rd(1'b0, d); check("R7 busy stays 0 code 111", d[5], 0);
    wr(1'b1, 8'h80);
    @(negedge clk); tmr_trig = 1'b1; @(negedge clk); tmr_trig = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 no request", nlog - n0, 0);
    wr(1'b1, 8'h00);
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_trig = 1'b1; @(negedge clk); tmr_trig = 1'b0;
  endtask

  task automatic t_trig();
    logic [7:0] d;
    int n0;
    wr(1'b0, 8'h02);
    n0 = nlog;
    wr(1'b1, 8'h00); pulse_tmr(); repeat (10) @(negedge clk);
    wr(1'b1, 8'h40); pulse_tmr(); repeat (10) @(negedge clk);
    check("R3 select 00/01 no start", nlog - n0, 0);
    wr(1'b1, 8'h80); pulse_tmr();
    @(negedge clk); pulse_tmr();
    repeat (15) @(negedge clk);
    check("R3 timer start once (R10 busy trigger ignored)", nlog - n0, 1);
    check("R3 timer channel", log_ch[n0], 2);
    rd(1'b0, d); check("R3 flag after timer run", d[7], 1);
    wr(1'b1, 8'hc0); pulse_tmr(); repeat (10) @(negedge clk);
    check("R3 timer ignored under pin select", nlog - n0, 1);
    ext_trig_n = 1'b0; repeat (5) @(negedge clk);
    ext_trig_n = 1'b1; repeat (15) @(negedge clk);
    check("R3 pin falling edge starts once", nlog - n0, 2);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_irq();
    wr(1'b0, 8'h02);
    wr(1'b0, 8'h22);
    wait_idle();
    check("R11 irq off without enable", irq, 0);
    wr(1'b0, 8'hc2);
    check("R11 irq on", irq, 1);
    wr(1'b0, 8'h42);
    check("R11 irq off after clear", irq, 0);
    wr(1'b0, 8'h02);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    int n0 = nlog;
    roff = 100;
    wr(1'b0, 8'h21);
    for (int i = 0; i < 20 && nlog == n0; i++) @(negedge clk);
    wr(1'b0, 8'h01);
    repeat (12) @(negedge clk);
    rd(1'b0, d);
    check("R12 aborted busy", d[5], 0);
    check("R12 aborted flag", d[7], 0);
    rd_ch = 3'd1; #1;
    check("R12 result kept", rd_result, 1 * 37 + 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_flag();
    t_scan(3'b011, 8, 0, 4);
    t_scan(3'b101, 4, 4, 2);
    t_scan(3'b100, 3, 4, 1);
    t_scan(3'b000, 3, 0, 1);
    t_lock();
    t_illegal();
    t_trig();
    t_irq();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule